// File: doc/BRIEF.md
# Two-Wide Register Rename Stage

This block renames up to two floating-point instructions in every clock cycle. Each instruction carries two architectural source register numbers and one architectural destination number. Each source is translated into the physical tag that currently holds its value. Each destination receives a fresh physical tag taken from a pool of free tags. The table is then updated so that later readers see the new tag.

The two slots of a group are in program order, and slot 0 is the older one. Slot 1 must see any mapping that slot 0 creates in the same group. This applies both to its sources and to the previous mapping it reports. For every destination the block also reports the tag that was mapped before. Commit logic outside the block later returns that tag through the free-push port.

If the pool holds fewer tags than the group needs, the group is held back as a whole. The stall output is combinational, so the upstream stage holds its inputs for the next cycle. Results are registered and appear one cycle after a group is accepted.

Top module: `rn_rename2`

## Requirements
- R1: After reset, architectural register r maps to physical tag r, and the free pool holds tags NUM_ARCH to NUM_PHYS-1 in ascending order.
- R2: Tags are handed out from the pool in sequence. In a group with both slots valid, slot 0 receives the earlier tag and slot 1 the next one, and the following group continues where this one ended.
- R3: Both destination entries of an accepted group are written in the same cycle, and the next group's lookups return the new tags.
- R4: When a source of slot 1 equals the destination of valid slot 0 in the same group, that source reports slot 0's newly allocated tag rather than the table value.
- R5: When both slots write the same architectural register, the table keeps slot 1's tag, and slot 1's previous-mapping output equals slot 0's new tag.
- R6: When the number of valid slots exceeds the number of free tags, stall is 1 in that same cycle. In that case no table entry changes, no tag is consumed, and no output slot is marked valid in the next cycle.
- R7: Each valid output slot reports the tag its destination was mapped to before this group, in the previous-mapping output.
- R8: Results of a group accepted at a clock edge appear on the outputs right after that edge. out_vld bit i (bit 0 = slot 0) is set exactly for the valid slots of the accepted group and is 0 otherwise.
- R9: A tag pushed through the free-push port joins the end of the pool. It can be allocated from the next cycle on, after all tags that were already in the pool.
- R10: A group with only one valid slot consumes exactly one tag, which that slot receives whichever slot it is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 2 | Slot valid bits; bit 0 is the older slot |
| in_src_a0 | input | ARCH_W | Slot 0 first source register |
| in_src_b0 | input | ARCH_W | Slot 0 second source register |
| in_dst0 | input | ARCH_W | Slot 0 destination register |
| in_src_a1 | input | ARCH_W | Slot 1 first source register |
| in_src_b1 | input | ARCH_W | Slot 1 second source register |
| in_dst1 | input | ARCH_W | Slot 1 destination register |
| free_push | input | 1 | Return one tag to the pool |
| free_tag | input | PTAG_W | Tag being returned |
| stall | output | 1 | Group cannot be accepted this cycle |
| out_vld | output | 2 | Renamed slot valid bits |
| out_pa0 | output | PTAG_W | Slot 0 first source tag |
| out_pb0 | output | PTAG_W | Slot 0 second source tag |
| out_pd0 | output | PTAG_W | Slot 0 new destination tag |
| out_old0 | output | PTAG_W | Slot 0 previous destination tag |
| out_pa1 | output | PTAG_W | Slot 1 first source tag |
| out_pb1 | output | PTAG_W | Slot 1 second source tag |
| out_pd1 | output | PTAG_W | Slot 1 new destination tag |
| out_old1 | output | PTAG_W | Slot 1 previous destination tag |

## Verification
The bench builds the block with NUM_ARCH = 8 and NUM_PHYS = 16, which gives a pool of only eight tags. Random groups therefore drain the pool within a few cycles, and stalls, single-slot groups and pool wrap-around all occur often. With only eight architectural registers, random register numbers often collide inside a group. This exercises the same-group bypass and the same-destination case without special steering.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned SLOTS = 2;

  function automatic logic [1:0] slot_count(input logic [1:0] v);
    return {1'b0, v[0]} + {1'b0, v[1]};
  endfunction
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  localparam int DEPTH  = NUM_PHYS - NUM_ARCH,
  localparam int PW     = $clog2(NUM_PHYS),
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       pop_n,
  input  logic             push,
  input  logic [PW-1:0]    push_tag,
  output logic [PW-1:0]    head0,
  output logic [PW-1:0]    head1,
  output logic [CNT_W-1:0] avail
);
  logic [PW-1:0]    ring [DEPTH];
  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] count;

  function automatic logic [IDX_W-1:0] inc(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head0 = ring[head];
  assign head1 = ring[inc(head)];
  assign avail = count;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ring[i] <= PW'(NUM_ARCH + i);
      head  <= '0;
      tail  <= '0;
      count <= CNT_W'(DEPTH);
    end else begin
      if (push) begin
        ring[tail] <= push_tag;
        tail       <= inc(tail);
      end
      case (pop_n)
        2'd1:    head <= inc(head);
        2'd2:    head <= inc(inc(head));
        default: head <= head;
      endcase
      count <= count + CNT_W'(push) - CNT_W'(pop_n);
    end
  end

  // R6: the rename logic never takes more tags than the pool holds
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    CNT_W'(pop_n) <= count);

  // R9: returned tags never overfill the pool
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    push |-> (count != CNT_W'(DEPTH)) || (pop_n != 2'd0));
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  parameter int NRD      = 6,
  parameter int NWR      = 2,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NRD-1:0][AW-1:0]  rd_addr,
  output logic [NRD-1:0][PW-1:0]  rd_data,
  input  logic [NWR-1:0]          wr_en,
  input  logic [NWR-1:0][AW-1:0]  wr_addr,
  input  logic [NWR-1:0][PW-1:0]  wr_data
);
  logic [PW-1:0] map [NUM_ARCH];

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = map[rd_addr[g]];
  end

  // Higher write port index is younger and is applied last, so it wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ARCH; i++) map[i] <= PW'(i);
    end else begin
      for (int w = 0; w < NWR; w++)
        if (wr_en[w]) map[wr_addr[w]] <= wr_data[w];
    end
  end

  // R5: on a same-register double write the youngest port's data is kept
  assert_younger_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en[0] && wr_en[NWR-1] && wr_addr[0] == wr_addr[NWR-1])
      |=> map[$past(wr_addr[NWR-1])] == $past(wr_data[NWR-1]));
endmodule

// File: rtl/rn_rename2.sv
module rn_rename2
  import rn_pkg::*;
#(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  localparam int ARCH_W = $clog2(NUM_ARCH),
  localparam int PTAG_W = $clog2(NUM_PHYS),
  localparam int CNT_W  = $clog2(NUM_PHYS - NUM_ARCH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        in_vld,
  input  logic [ARCH_W-1:0] in_src_a0,
  input  logic [ARCH_W-1:0] in_src_b0,
  input  logic [ARCH_W-1:0] in_dst0,
  input  logic [ARCH_W-1:0] in_src_a1,
  input  logic [ARCH_W-1:0] in_src_b1,
  input  logic [ARCH_W-1:0] in_dst1,
  input  logic              free_push,
  input  logic [PTAG_W-1:0] free_tag,
  output logic              stall,
  output logic [1:0]        out_vld,
  output logic [PTAG_W-1:0] out_pa0,
  output logic [PTAG_W-1:0] out_pb0,
  output logic [PTAG_W-1:0] out_pd0,
  output logic [PTAG_W-1:0] out_old0,
  output logic [PTAG_W-1:0] out_pa1,
  output logic [PTAG_W-1:0] out_pb1,
  output logic [PTAG_W-1:0] out_pd1,
  output logic [PTAG_W-1:0] out_old1
);
  logic [1:0]              need;
  logic                    accept;
  logic [CNT_W-1:0]        avail;
  logic [PTAG_W-1:0]       head0, head1, tag0, tag1;
  logic [5:0][ARCH_W-1:0]  rd_addr;
  logic [5:0][PTAG_W-1:0]  rd_data;
  logic [1:0][ARCH_W-1:0]  wr_addr;
  logic [1:0][PTAG_W-1:0]  wr_data;
  logic [PTAG_W-1:0]       pa1_n, pb1_n, old1_n;

  assign need   = slot_count(in_vld);
  assign stall  = CNT_W'(need) > avail;
  assign accept = (|in_vld) && !stall;

  rn_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
    .clk      (clk),
    .rst      (rst),
    .pop_n    (accept ? need : 2'd0),
    .push     (free_push),
    .push_tag (free_tag),
    .head0    (head0),
    .head1    (head1),
    .avail    (avail)
  );

  // Older slot takes the head; the younger slot takes the next one only
  // when the older slot is also allocating.
  assign tag0 = head0;
  assign tag1 = in_vld[0] ? head1 : head0;

  assign rd_addr = {in_dst1, in_src_b1, in_src_a1, in_dst0, in_src_b0, in_src_a0};
  assign wr_addr = {in_dst1, in_dst0};
  assign wr_data = {tag1, tag0};

  rn_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NRD(6), .NWR(SLOTS)) u_map (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (accept ? in_vld : 2'b00),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  // Same-group dependency bypass for the younger slot
  always_comb begin
    pa1_n  = (in_vld[0] && in_src_a1 == in_dst0) ? tag0 : rd_data[3];
    pb1_n  = (in_vld[0] && in_src_b1 == in_dst0) ? tag0 : rd_data[4];
    old1_n = (in_vld[0] && in_dst1   == in_dst0) ? tag0 : rd_data[5];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 2'b00;
      out_pa0  <= '0; out_pb0 <= '0; out_pd0 <= '0; out_old0 <= '0;
      out_pa1  <= '0; out_pb1 <= '0; out_pd1 <= '0; out_old1 <= '0;
    end else begin
      out_vld <= accept ? in_vld : 2'b00;
      if (accept) begin
        out_pa0  <= rd_data[0];
        out_pb0  <= rd_data[1];
        out_pd0  <= tag0;
        out_old0 <= rd_data[2];
        out_pa1  <= pa1_n;
        out_pb1  <= pb1_n;
        out_pd1  <= tag1;
        out_old1 <= old1_n;
      end
    end
  end

  // R6: a stalled group produces no renamed output
  assert_stall_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    stall |=> out_vld == 2'b00);

  // R2: two allocations in one group never share a tag
  assert_distinct_tags_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && in_vld == 2'b11) |=> out_pd0 != out_pd1);

  // R4: younger source on older destination sees the new tag
  assert_bypass_a_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && in_vld == 2'b11 && in_src_a1 == in_dst0) |=> out_pa1 == out_pd0);

  // R5: same destination in both slots chains the previous mapping
  assert_same_dst_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && in_vld == 2'b11 && in_dst0 == in_dst1) |=> out_old1 == out_pd0);

  // R8: output valid mirrors the accepted slot mask
  assert_out_mask_R8: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_vld == $past(in_vld));
endmodule

// File: tb/rn_rename2_bench.sv
`timescale 1ns/1ps
module rn_rename2_bench;
  localparam int NA = 8;
  localparam int NP = 16;
  localparam int FD = NP - NA;
  localparam int AW = $clog2(NA);
  localparam int PW = $clog2(NP);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] in_vld = 2'b00;
  logic [AW-1:0] in_src_a0 = '0, in_src_b0 = '0, in_dst0 = '0;
  logic [AW-1:0] in_src_a1 = '0, in_src_b1 = '0, in_dst1 = '0;
  logic free_push = 1'b0;
  logic [PW-1:0] free_tag = '0;
  logic stall;
  logic [1:0] out_vld;
  logic [PW-1:0] out_pa0, out_pb0, out_pd0, out_old0;
  logic [PW-1:0] out_pa1, out_pb1, out_pd1, out_old1;

  always #5 clk = ~clk;

  rn_rename2 #(.NUM_ARCH(NA), .NUM_PHYS(NP)) u_rn_rename2 (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .in_src_a0(in_src_a0), .in_src_b0(in_src_b0), .in_dst0(in_dst0),
    .in_src_a1(in_src_a1), .in_src_b1(in_src_b1), .in_dst1(in_dst1),
    .free_push(free_push), .free_tag(free_tag), .stall(stall), .out_vld(out_vld),
    .out_pa0(out_pa0), .out_pb0(out_pb0), .out_pd0(out_pd0), .out_old0(out_old0),
    .out_pa1(out_pa1), .out_pb1(out_pb1), .out_pd1(out_pd1), .out_old1(out_old1)
  );

  int nvec = 0;
  int nfail = 0;

  // Reference state built from the requirements
  int mmap [NA];
  int fq [FD];
  int fh, ft, fc;
  int pend [64];
  int ph, pt, pc;

  task automatic chk(input string req, input string what, input int got, input int exp);
    nvec++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NA; i++) mmap[i] = i;          // R1
    for (int i = 0; i < FD; i++) fq[i] = NA + i;
    fh = 0; ft = 0; fc = FD;
    ph = 0; pt = 0; pc = 0;
  endtask

  task automatic add_pend(input int t);
    pend[pt] = t; pt = (pt + 1) % 64; pc++;
  endtask

  task automatic step(input logic [1:0] v, input int a0, input int b0, input int d0,
                      input int a1, input int b1, input int d1, input bit want_push);
    int need, t0, t1, ptag;
    bit stl, dopush;
    int e_pa0, e_pb0, e_old0, e_pa1, e_pb1, e_old1;
    @(negedge clk);
    in_vld = v;
    in_src_a0 = AW'(a0); in_src_b0 = AW'(b0); in_dst0 = AW'(d0);
    in_src_a1 = AW'(a1); in_src_b1 = AW'(b1); in_dst1 = AW'(d1);
    dopush = want_push && (pc > 0);
    ptag = dopush ? pend[ph] : 0;
    free_push = dopush;
    free_tag = PW'(ptag);
    need = int'(v[0]) + int'(v[1]);
    stl = need > fc;
    t0 = fq[fh];
    t1 = v[0] ? fq[(fh + 1) % FD] : fq[fh];
    e_pa0 = mmap[a0]; e_pb0 = mmap[b0]; e_old0 = mmap[d0];
    e_pa1 = (v[0] && a1 == d0) ? t0 : mmap[a1];
    e_pb1 = (v[0] && b1 == d0) ? t0 : mmap[b1];
    e_old1 = (v[0] && d1 == d0) ? t0 : mmap[d1];
    #1;
    chk("R6", "stall", int'(stall), int'(stl));
    if (!stl && need > 0) begin
      if (v[0]) begin mmap[d0] = t0; add_pend(e_old0); end
      if (v[1]) begin mmap[d1] = t1; add_pend(e_old1); end
      fh = (fh + need) % FD; fc -= need;
    end
    if (dopush) begin
      ph = (ph + 1) % 64; pc--;
      fq[ft] = ptag; ft = (ft + 1) % FD; fc++;
    end
    @(posedge clk);
    #1;
    free_push = 1'b0;
    chk("R8", "out_vld", int'(out_vld), stl ? 0 : int'(v));
    if (!stl && v[0]) begin
      chk("R3", "pa0", int'(out_pa0), e_pa0);
      chk("R3", "pb0", int'(out_pb0), e_pb0);
      chk("R2", "pd0", int'(out_pd0), t0);
      chk("R7", "old0", int'(out_old0), e_old0);
    end
    if (!stl && v[1]) begin
      chk("R4", "pa1", int'(out_pa1), e_pa1);
      chk("R4", "pb1", int'(out_pb1), e_pb1);
      chk("R10", "pd1", int'(out_pd1), t1);
      chk("R5", "old1", int'(out_old1), e_old1);
    end
  endtask

  initial begin
    #(200000 * 10);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R8", "reset out_vld", int'(out_vld), 0);
    chk("R6", "reset stall", int'(stall), 0);

    // R1 R2 R4 R5: first pair after reset, both slots write r3
    step(2'b11, 1, 2, 3, 3, 5, 3, 1'b0);
    chk("R1", "pa0 identity", int'(out_pa0), 1);
    chk("R2", "first tag", int'(out_pd0), 8);
    chk("R2", "second tag", int'(out_pd1), 9);
    chk("R4", "bypass pa1", int'(out_pa1), 8);
    chk("R5", "chained old1", int'(out_old1), 8);
    // R5 table kept younger tag; R2 sequence continues
    step(2'b11, 3, 0, 4, 4, 6, 6, 1'b0);
    chk("R5", "r3 holds younger", int'(out_pa0), 9);
    chk("R2", "next pair first", int'(out_pd0), 10);
    chk("R2", "next pair second", int'(out_pd1), 11);
    chk("R7", "old1 identity", int'(out_old1), 6);
    // R10 R3: lone younger slot
    step(2'b10, 0, 0, 0, 6, 1, 7, 1'b0);
    chk("R3", "sees new r6", int'(out_pa1), 11);
    chk("R10", "lone slot tag", int'(out_pd1), 12);
    // Drain to one free tag, then a pair must stall
    step(2'b11, 0, 0, 1, 0, 0, 2, 1'b0);
    step(2'b11, 1, 2, 5, 0, 0, 0, 1'b0);
    chk("R6", "stalled mask", int'(out_vld), 0);
    step(2'b01, 1, 2, 5, 0, 0, 0, 1'b0);
    chk("R6", "r1 after stall", int'(out_pa0), 13);
    chk("R6", "no tag lost", int'(out_pd0), 15);
    // R9: pool empty, return first freed tag (3), then allocate it
    step(2'b00, 0, 0, 0, 0, 0, 0, 1'b1);
    step(2'b01, 0, 0, 0, 0, 0, 0, 1'b0);
    chk("R9", "recycled tag", int'(out_pd0), 3);

    for (int n = 0; n < 3000; n++) begin
      step(2'($urandom % 4),
           int'($urandom % NA), int'($urandom % NA), int'($urandom % NA),
           int'($urandom % NA), int'($urandom % NA), int'($urandom % NA),
           ($urandom % 3) != 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule